// File: doc/BRIEF.md
# Two-Wire Memory Write-Completion Poller

A two-wire serial memory starts its self-timed internal programming as soon as the master closes a write command with a Stop. It does not acknowledge its own address while that programming runs. This block is a bus-master sequencer that uses that silence to learn when the memory is ready. A fixed worst-case delay is not used.

On a request, the block stores the 7-bit device address and starts probing at once. Each probe is a Start followed by one byte that holds the device address with the direction bit cleared. The bit-level engine reports whether the byte was acknowledged:

- **No acknowledge:** the block releases the bus with a Stop and probes again.
- **Acknowledge:** the block pulses `done_o` and leaves the bus open, so the next read or write can follow on the same transaction.
- **Limit reached:** a programmable attempt limit bounds the loop. When a probe goes unanswered and no attempts remain, the block issues a Stop and pulses `timeout_o`.

The bit-level engine exchanges one operation at a time with the block through a valid/complete handshake.

Top module: `wrp_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o` and `op_valid_o` are all 0.
- R2: A `req_i` sampled while idle raises `busy_o` on the next cycle. In that same cycle the first operation is offered: `op_valid_o`=1 and `op_code_o`=START.
- R3: Every attempt is a START followed by a BYTE operation. The BYTE carries `op_data_o` = {stored address, 1'b0}, with bit 0 (the direction bit) equal to 0.
- R4: When a BYTE completes with `eng_nack_i`=1 and attempts remain, the next operation is STOP, followed by a new START.
- R5: When a BYTE completes with `eng_nack_i`=0, `done_o` is 1 for exactly one cycle, `busy_o` falls in that same cycle, and no STOP is issued.
- R6: When the BYTE of the final permitted attempt completes with `eng_nack_i`=1, a STOP is issued. When that STOP completes, `timeout_o` is 1 for exactly one cycle and `busy_o` falls in that cycle.
- R7: `try_limit_i` gives the maximum number of attempts, and a value of 0 is treated as 1.
- R8: A `req_i` sampled while `busy_o`=1 is ignored. The stored address does not change and no additional sequence follows completion.
- R9: Once `op_valid_o` is raised, it stays 1 and `op_code_o`/`op_data_o` stay stable until the cycle in which `eng_done_i`=1 is sampled. While not busy, `op_valid_o` is 0.
- R10: Operation codes are START=2'd0, BYTE=2'd1, STOP=2'd2. Outside BYTE, `op_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start polling (taken only when idle) |
| dev_addr_i | input | 7 | Device address captured with the request |
| try_limit_i | input | CNT_W | Maximum attempts (0 acts as 1) |
| op_valid_o | output | 1 | Operation offered to the bit engine |
| op_code_o | output | 2 | 0 START, 1 BYTE, 2 STOP |
| op_data_o | output | 8 | Byte to send for BYTE |
| eng_done_i | input | 1 | One-cycle pulse: offered operation finished |
| eng_nack_i | input | 1 | With eng_done_i on BYTE: 1 = not acknowledged |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle pulse: device acknowledged |
| timeout_o | output | 1 | One-cycle pulse: attempt limit exhausted |

## Verification
The properties assume the engine obeys the handshake: `eng_done_i` pulses for a single cycle, only while `op_valid_o` is high, and `eng_nack_i` has meaning only alongside a completed BYTE. The bench's engine model follows this contract. It waits a chosen number of cycles after `op_valid_o` rises, pulses completion once, then drops it before the next operation appears. The model plays a device that stays busy for a chosen number of address bytes. It is swept against every small attempt limit, including zero, and a stray request is injected mid-sequence.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_STOP_RETRY,
        S_STOP_TMO
    } st_e;

    typedef struct packed {
        st_e  st;
        logic busy;
        logic done;
        logic tmo;
    } ctrl_t;

endpackage

// File: rtl/wrp_try_cnt.sv
module wrp_try_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [EXT_W-1:0] eff_lim;
    logic [EXT_W-1:0] next_try;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
        // zero limit still allows one attempt
        eff_lim  = (limit_i == '0) ? EXT_W'(1) : {1'b0, limit_i};
        next_try = {1'b0, cnt_q} + EXT_W'(1);
        last_o   = (next_try >= eff_lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wrp_op_fmt.sv
module wrp_op_fmt
    import wrp_pkg::*;
#(
    parameter int DEV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DEV_W-1:0] addr_i,
    input  st_e              st_i,
    output logic             op_valid_o,
    output logic [1:0]       op_code_o,
    output logic [DEV_W:0]   op_data_o
);
    logic [DEV_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d     = load_i ? addr_i : addr_q;
        op_valid_o = 1'b0;
        op_code_o  = OP_START;
        op_data_o  = '0;
        unique case (st_i)
            S_START: begin
                op_valid_o = 1'b1;
                op_code_o  = OP_START;
            end
            S_ADDR: begin
                op_valid_o = 1'b1;
                op_code_o  = OP_BYTE;
                op_data_o  = {addr_q, 1'b0};
            end
            S_STOP_RETRY, S_STOP_TMO: begin
                op_valid_o = 1'b1;
                op_code_o  = OP_STOP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end
endmodule

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
    import wrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic eng_done_i,
    input  logic eng_nack_i,
    input  logic last_i,
    output st_e  st_o,
    output logic load_o,
    output logic cnt_clr_o,
    output logic cnt_inc_o,
    output logic busy_o,
    output logic done_o,
    output logic tmo_o
);
    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.tmo  = 1'b0;
        unique case (c_q.st)
            S_IDLE: begin
                if (req_i) begin
                    c_d.st   = S_START;
                    c_d.busy = 1'b1;
                end
            end
            S_START: begin
                if (eng_done_i) c_d.st = S_ADDR;
            end
            S_ADDR: begin
                if (eng_done_i) begin
                    if (!eng_nack_i) begin
                        c_d.st   = S_IDLE;
                        c_d.busy = 1'b0;
                        c_d.done = 1'b1;
                    end else if (last_i) begin
                        c_d.st = S_STOP_TMO;
                    end else begin
                        c_d.st = S_STOP_RETRY;
                    end
                end
            end
            S_STOP_RETRY: begin
                if (eng_done_i) c_d.st = S_START;
            end
            S_STOP_TMO: begin
                if (eng_done_i) begin
                    c_d.st   = S_IDLE;
                    c_d.busy = 1'b0;
                    c_d.tmo  = 1'b1;
                end
            end
            default: begin
                c_d.st   = S_IDLE;
                c_d.busy = 1'b0;
            end
        endcase

        st_o      = c_q.st;
        load_o    = (c_q.st == S_IDLE) && req_i;
        cnt_clr_o = load_o;
        cnt_inc_o = (c_q.st == S_ADDR) && eng_done_i;
        busy_o    = c_q.busy;
        done_o    = c_q.done;
        tmo_o     = c_q.tmo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st   <= S_IDLE;
            c_q.busy <= 1'b0;
            c_q.done <= 1'b0;
            c_q.tmo  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/wrp_poller.sv
module wrp_poller
    import wrp_pkg::*;
#(
    parameter int DEV_W = 7,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [DEV_W-1:0] dev_addr_i,
    input  logic [CNT_W-1:0] try_limit_i,
    output logic             op_valid_o,
    output logic [1:0]       op_code_o,
    output logic [DEV_W:0]   op_data_o,
    input  logic             eng_done_i,
    input  logic             eng_nack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o
);
    st_e  st;
    logic load, cnt_clr, cnt_inc, last_try;

    wrp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .eng_done_i (eng_done_i),
        .eng_nack_i (eng_nack_i),
        .last_i     (last_try),
        .st_o       (st),
        .load_o     (load),
        .cnt_clr_o  (cnt_clr),
        .cnt_inc_o  (cnt_inc),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .tmo_o      (timeout_o)
    );

    wrp_try_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .limit_i (try_limit_i),
        .last_o  (last_try)
    );

    wrp_op_fmt #(.DEV_W(DEV_W)) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .addr_i     (dev_addr_i),
        .st_i       (st),
        .op_valid_o (op_valid_o),
        .op_code_o  (op_code_o),
        .op_data_o  (op_data_o)
    );
endmodule

// File: rtl/wrp_poller_chk.sv
module wrp_poller_chk #(
    parameter int DEV_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_i,
    input logic           op_valid_o,
    input logic [1:0]     op_code_o,
    input logic [DEV_W:0] op_data_o,
    input logic           eng_done_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           timeout_o
);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !eng_done_i) |=> (op_valid_o && $stable(op_code_o) && $stable(op_data_o)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !op_valid_o);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    a_r5_busy_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> !busy_o);

    a_r8_busy_until_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || timeout_o));

    a_r2_rise_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(req_i) && op_valid_o && op_code_o == 2'd0));

    a_r3_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && op_code_o == 2'd1) |-> !op_data_o[0]);

    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> (op_code_o != 2'd3));
endmodule

bind wrp_poller wrp_poller_chk #(.DEV_W(DEV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .op_valid_o (op_valid_o),
    .op_code_o  (op_code_o),
    .op_data_o  (op_data_o),
    .eng_done_i (eng_done_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o)
);

// File: tb/sim_wrp_poller.sv
module sim_wrp_poller;
    localparam int DEV_W = 7;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [DEV_W-1:0] dev_addr_i = '0;
    logic [CNT_W-1:0] try_limit_i = '0;
    logic             op_valid_o;
    logic [1:0]       op_code_o;
    logic [DEV_W:0]   op_data_o;
    logic             eng_done_i = 1'b0;
    logic             eng_nack_i = 1'b0;
    logic             busy_o, done_o, timeout_o;

    always #2.5 clk = ~clk;

    wrp_poller #(.DEV_W(DEV_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dev_addr_i(dev_addr_i),
        .try_limit_i(try_limit_i), .op_valid_o(op_valid_o), .op_code_o(op_code_o),
        .op_data_o(op_data_o), .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    int total = 0, bad = 0, cyc = 0;
    int lat = 0, nack_left = 0, wait_c = 0;
    int n_start = 0, n_byte = 0, n_stop = 0, order_err = 0, addr_err = 0, data_err = 0;
    int prev_op = -1;
    int n_done = 0, n_tmo = 0;
    logic [DEV_W-1:0] exp_addr = '0;

    // engine model: a device busy for nack_left address bytes
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done_i <= 1'b0;
            eng_nack_i <= 1'b0;
            wait_c = 0;
        end else if (eng_done_i) begin
            eng_done_i <= 1'b0;
            eng_nack_i <= 1'b0;
            wait_c = 0;
            case (op_code_o)
                2'd0: begin
                    n_start++;
                    if (prev_op != -1 && prev_op != 2) order_err++;
                    if (op_data_o != 0) data_err++;
                end
                2'd1: begin
                    n_byte++;
                    if (prev_op != 0) order_err++;
                    if (op_data_o != {exp_addr, 1'b0}) addr_err++;
                end
                2'd2: begin
                    n_stop++;
                    if (prev_op != 1) order_err++;
                    if (op_data_o != 0) data_err++;
                end
                default: order_err++;
            endcase
            prev_op = int'(op_code_o);
        end else if (op_valid_o) begin
            if (wait_c >= lat) begin
                eng_done_i <= 1'b1;
                if (op_code_o == 2'd1 && nack_left > 0) begin
                    eng_nack_i <= 1'b1;
                    nack_left--;
                end else begin
                    eng_nack_i <= 1'b0;
                end
            end else begin
                wait_c++;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && done_o) n_done++;
        if (rst_n && timeout_o) n_tmo++;
    end

    task automatic check(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic run_case(input int lim, input int busy_n, input int l, input logic [DEV_W-1:0] a,
                            input bit stray);
        int eff, guard;
        eff = (lim == 0) ? 1 : lim;
        @(negedge clk);
        lat = l; nack_left = busy_n; prev_op = -1;
        n_start = 0; n_byte = 0; n_stop = 0; order_err = 0; addr_err = 0; data_err = 0;
        n_done = 0; n_tmo = 0;
        exp_addr = a;
        dev_addr_i = a;
        try_limit_i = CNT_W'(lim);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check("R2 busy after request", int'(busy_o), 1);
        check("R2 first op START", int'(op_valid_o && op_code_o == 2'd0), 1);
        guard = 0;
        while (n_done + n_tmo == 0 && guard < 400) begin
            if (stray && guard == 1) begin
                dev_addr_i = a ^ 7'h55;
                req_i = 1'b1;
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        req_i = 1'b0;
        check("R9 case finished", int'(guard < 400), 1);
        if (busy_n < eff) begin
            check("R5 done pulses", n_done, 1);
            check("R5 timeout absent", n_tmo, 0);
            check("R4 attempts", n_byte, busy_n + 1);
            check("R4 starts", n_start, busy_n + 1);
            check("R5 stops (none after ack)", n_stop, busy_n);
        end else begin
            check("R6 timeout pulses", n_tmo, 1);
            check("R6 done absent", n_done, 0);
            check("R7 attempts at limit", n_byte, eff);
            check("R7 starts at limit", n_start, eff);
            check("R6 stops", n_stop, eff);
        end
        check("R3 order START-BYTE-STOP", order_err, 0);
        check(stray ? "R8 address kept" : "R3 address byte", addr_err, 0);
        check("R10 data zero outside BYTE", data_err, 0);
        check("R5 busy low at end", int'(busy_o), 0);
        repeat (4) begin
            @(negedge clk);
            if (op_valid_o || busy_o) begin
                check("R8 no extra sequence", 1, 0);
            end
        end
        check("R8 no extra completions", n_done + n_tmo, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 done reset", int'(done_o), 0);
        check("R1 timeout reset", int'(timeout_o), 0);
        check("R1 op_valid reset", int'(op_valid_o), 0);
        rst_n = 1'b1;
        for (int lim = 0; lim <= 4; lim++) begin
            for (int b = 0; b <= 5; b++) begin
                run_case(lim, b, (lim + b) % 3, DEV_W'(lim * 17 + b * 5 + 1), ((lim + b) % 2) == 1);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++;
        bad++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule